// File: doc/BRIEF.md
# Flash Mode Configuration Sequencer

This block places a serial NOR flash into one of three working profiles (plain, fast, quad fast) by driving a command-level port. The port carries an opcode, an address byte count, a dummy cycle count, a byte length and up to eight data bytes, with a request pulse out and a completion pulse back. Each profile change runs two read-modify-write passes. The first pass rewrites the lane-select byte of the flash, which picks single, dual or quad transfers. The second pass rewrites the dummy-count byte, which sets the dummy cycles for fast reads. Every pass reads the byte, edits only the bits it owns, issues write enable, and then writes the byte back.

After a successful run, the block presents the read opcode, read dummy count, program opcode, program dummy count and host lane mode that the downstream transfer engine should use. A restore request brings the flash back to single lane and 8 dummy cycles, clears the presented profile and marks the device not initialised. Host software starts a run with a single request pulse and waits for the done pulse and a status code.

Top module: `flash_mode_seq`

## Requirements
- R1: After reset, busy, done, status, cmd_req, inited, host_lane (0 = single), and all presented opcodes and dummy counts are zero.
- R2: An accepted request issues exactly six commands, in this order: 0x65 (read lane byte), 0x06 (write enable), 0x61 (write lane byte), 0x85 (read dummy byte), 0x06, 0x81 (write dummy byte). Every one of them uses 0 address bytes and 0 dummies. The register reads and writes move 1 byte (cmd_len = 1), and write enable moves 0 bytes. cmd_wr is 1 for writes and write enable.
- R3: The written lane byte keeps bits 5:0 of the byte that was read. Bit 7 is the quad-disable bit and bit 6 is the dual-disable bit (0 = enabled). Single lane sets both bits, and quad sets bit 6 and clears bit 7.
- R4: The written dummy byte holds the new dummy count in bits 7:4 and keeps bits 3:0 of the byte that was read. Only byte 0 of cmd_rdata is used.
- R5: req_state 0 (plain) presents read 0x03 with 0 dummies and program 0x02 with 0 dummies, writes 0 to the dummy field and selects single lane. req_state 1 (fast) presents read 0x0B with 8 dummies and program 0x02, writes 8 and selects single lane. req_state 2 (quad fast) presents read 0x6B with 10 dummies and program 0x32 with 0 dummies, writes 10 and selects quad. inited goes to 1 on success.
- R6: host_lane changes only in the cycle after the completion of the lane-byte write (0x61), and never before that write completes.
- R7: A request with req_restore = 1 selects single lane, writes 8 to the dummy field, sets every presented opcode and dummy count to 0, and clears inited.
- R8: req_state 3 without restore issues no command. It gives a done pulse in the next cycle with status 0xF and leaves busy low.
- R9: A nonzero cmd_err on a completion ends the run at once. No further command is issued, status takes the error code, and the presented profile stays unchanged. host_lane has already moved only if the lane-byte write had completed.
- R10: busy rises the cycle after acceptance and falls in the same cycle as done. req_valid is ignored while busy is high.
- R11: done lasts exactly one cycle. status is 0 after a successful run and holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start pulse |
| req_restore | input | 1 | 1: restore-to-reset run |
| req_state | input | 2 | Profile code: 0 plain, 1 fast, 2 quad fast |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 4 | 0 ok, 0xF bad profile, else command error |
| cmd_req | output | 1 | One-cycle command issue pulse |
| cmd_opcode | output | 8 | Command opcode |
| cmd_wr | output | 1 | 1 for write direction |
| cmd_addr_bytes | output | 3 | Address byte count |
| cmd_dummy | output | 5 | Dummy cycles |
| cmd_len | output | 4 | Data byte count |
| cmd_wdata | output | 64 | Write data, byte 0 first |
| cmd_done | input | 1 | Command completion pulse |
| cmd_err | input | 4 | Completion error code, 0 = ok |
| cmd_rdata | input | 64 | Read data, byte 0 first |
| host_lane | output | 2 | Host lane mode: 0 single, 1 dual, 2 quad |
| rd_opcode | output | 8 | Read opcode for the transfer engine |
| rd_dummy | output | 5 | Read dummy cycles |
| pg_opcode | output | 8 | Program opcode |
| pg_dummy | output | 5 | Program dummy cycles |
| inited | output | 1 | Device configured |

## Verification
Assertions check on every cycle the properties of each issued command: its byte length, zero dummy cycles and zero address bytes, and the rule that a write enable comes right before each register write. They also check that host_lane moves only right after a completed lane-byte write, that done is a single pulse that ends busy, and that no command is issued outside a run. The bit edits, the per-profile values and the abort behaviour are shown only by the bench. Its flash model holds the two bytes from random start values, applies the writes it receives and injects errors at chosen positions in the run, and the bench compares the resulting bytes and outputs with its own expected values.

// File: rtl/fms_pkg.sv
package fms_pkg;
    localparam int DATA_BYTES = 8;
    localparam int ERR_W      = 4;
    localparam int DUMMY_W    = 5;
    localparam int LEN_W      = $clog2(DATA_BYTES + 1);
    localparam int STEP_W     = 3;
    localparam int LAST_STEP  = 5;

    localparam logic [7:0] OP_RD_LANE = 8'h65;
    localparam logic [7:0] OP_WR_LANE = 8'h61;
    localparam logic [7:0] OP_RD_DUMY = 8'h85;
    localparam logic [7:0] OP_WR_DUMY = 8'h81;
    localparam logic [7:0] OP_WREN    = 8'h06;

    localparam logic [ERR_W-1:0] ST_BAD_ARG = '1;

    typedef enum logic [1:0] {
        LANE_SINGLE = 2'd0,
        LANE_DUAL   = 2'd1,
        LANE_QUAD   = 2'd2
    } lane_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e               phase;
        logic [STEP_W-1:0]    step;
        logic [7:0]           rbuf;
        logic                 restore;
        logic [1:0]           fsel;
        lane_e                lane;
        logic [7:0]           rd_op;
        logic [DUMMY_W-1:0]   rd_dm;
        logic [7:0]           pg_op;
        logic [DUMMY_W-1:0]   pg_dm;
        logic                 inited;
        logic                 busy;
        logic                 done;
        logic [ERR_W-1:0]     status;
    } regs_t;
endpackage

// File: rtl/fms_profile.sv
module fms_profile
    import fms_pkg::*;
(
    input  logic               restore,
    input  logic [1:0]         fsel,
    output lane_e              lane_tgt,
    output logic [7:0]         rd_op,
    output logic [DUMMY_W-1:0] rd_dm,
    output logic [7:0]         pg_op,
    output logic [DUMMY_W-1:0] pg_dm,
    output logic [3:0]         field_dm
);
    always_comb begin
        lane_tgt = LANE_SINGLE;
        rd_op    = 8'h03;
        rd_dm    = '0;
        pg_op    = 8'h02;
        pg_dm    = '0;
        field_dm = 4'd0;
        if (restore) begin
            field_dm = 4'd8;
        end else begin
            case (fsel)
                2'd1: begin
                    rd_op    = 8'h0B;
                    rd_dm    = DUMMY_W'(8);
                    field_dm = 4'd8;
                end
                2'd2: begin
                    lane_tgt = LANE_QUAD;
                    rd_op    = 8'h6B;
                    rd_dm    = DUMMY_W'(10);
                    pg_op    = 8'h32;
                    field_dm = 4'd10;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fms_cmd_gen.sv
module fms_cmd_gen
    import fms_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  lane_e             lane_tgt,
    input  logic [3:0]        field_dm,
    input  logic [7:0]        rbuf,
    output logic [7:0]        opcode,
    output logic              wr,
    output logic [LEN_W-1:0]  len,
    output logic [7:0]        wbyte
);
    logic [7:0] lane_byte;

    always_comb begin
        case (lane_tgt)
            LANE_DUAL: lane_byte = {2'b10, rbuf[5:0]};
            LANE_QUAD: lane_byte = {2'b01, rbuf[5:0]};
            default:   lane_byte = {2'b11, rbuf[5:0]};
        endcase
    end

    always_comb begin
        opcode = OP_WREN;
        wr     = 1'b1;
        len    = '0;
        wbyte  = '0;
        case (step)
            3'd0: begin opcode = OP_RD_LANE; wr = 1'b0; len = LEN_W'(1); end
            3'd2: begin opcode = OP_WR_LANE; len = LEN_W'(1); wbyte = lane_byte; end
            3'd3: begin opcode = OP_RD_DUMY; wr = 1'b0; len = LEN_W'(1); end
            3'd5: begin opcode = OP_WR_DUMY; len = LEN_W'(1); wbyte = {field_dm, rbuf[3:0]}; end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_mode_seq.sv
module flash_mode_seq
    import fms_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_restore,
    input  logic [1:0]                req_state,
    output logic                      busy,
    output logic                      done,
    output logic [ERR_W-1:0]          status,
    output logic                      cmd_req,
    output logic [7:0]                cmd_opcode,
    output logic                      cmd_wr,
    output logic [2:0]                cmd_addr_bytes,
    output logic [DUMMY_W-1:0]        cmd_dummy,
    output logic [LEN_W-1:0]          cmd_len,
    output logic [8*DATA_BYTES-1:0]   cmd_wdata,
    input  logic                      cmd_done,
    input  logic [ERR_W-1:0]          cmd_err,
    input  logic [8*DATA_BYTES-1:0]   cmd_rdata,
    output logic [1:0]                host_lane,
    output logic [7:0]                rd_opcode,
    output logic [DUMMY_W-1:0]        rd_dummy,
    output logic [7:0]                pg_opcode,
    output logic [DUMMY_W-1:0]        pg_dummy,
    output logic                      inited
);
    regs_t q, d;

    lane_e              p_lane;
    logic [7:0]         p_rd_op, p_pg_op, wbyte;
    logic [DUMMY_W-1:0] p_rd_dm, p_pg_dm;
    logic [3:0]         p_field;

    // Only byte 0 of a register read is meaningful.
    logic unused_rdata_hi;
    assign unused_rdata_hi = ^cmd_rdata[8*DATA_BYTES-1:8];

    fms_profile u_profile (
        .restore  (q.restore),
        .fsel     (q.fsel),
        .lane_tgt (p_lane),
        .rd_op    (p_rd_op),
        .rd_dm    (p_rd_dm),
        .pg_op    (p_pg_op),
        .pg_dm    (p_pg_dm),
        .field_dm (p_field)
    );

    fms_cmd_gen u_cmd_gen (
        .step     (q.step),
        .lane_tgt (p_lane),
        .field_dm (p_field),
        .rbuf     (q.rbuf),
        .opcode   (cmd_opcode),
        .wr       (cmd_wr),
        .len      (cmd_len),
        .wbyte    (wbyte)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (!req_restore && req_state == 2'd3) begin
                        d.done   = 1'b1;
                        d.status = ST_BAD_ARG;
                    end else begin
                        d.phase   = PH_ISSUE;
                        d.step    = '0;
                        d.restore = req_restore;
                        d.fsel    = req_state;
                        d.busy    = 1'b1;
                        d.status  = '0;
                    end
                end
            end
            PH_ISSUE: d.phase = PH_WAIT;
            PH_WAIT: begin
                if (cmd_done) begin
                    if (cmd_err != '0) begin
                        d.phase  = PH_IDLE;
                        d.busy   = 1'b0;
                        d.done   = 1'b1;
                        d.status = cmd_err;
                    end else begin
                        if (q.step == 3'd0 || q.step == 3'd3)
                            d.rbuf = cmd_rdata[7:0];
                        if (q.step == 3'd2)
                            d.lane = p_lane;
                        if (q.step == STEP_W'(LAST_STEP)) begin
                            d.phase  = PH_IDLE;
                            d.busy   = 1'b0;
                            d.done   = 1'b1;
                            d.inited = !q.restore;
                            d.rd_op  = q.restore ? '0 : p_rd_op;
                            d.rd_dm  = q.restore ? '0 : p_rd_dm;
                            d.pg_op  = q.restore ? '0 : p_pg_op;
                            d.pg_dm  = q.restore ? '0 : p_pg_dm;
                        end else begin
                            d.step  = q.step + 1'b1;
                            d.phase = PH_ISSUE;
                        end
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.lane  <= LANE_SINGLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_req        = (q.phase == PH_ISSUE);
    assign cmd_addr_bytes = '0;
    assign cmd_dummy      = '0;
    assign cmd_wdata      = {{(8*DATA_BYTES-8){1'b0}}, wbyte};
    assign busy      = q.busy;
    assign done      = q.done;
    assign status    = q.status;
    assign host_lane = q.lane;
    assign rd_opcode = q.rd_op;
    assign rd_dummy  = q.rd_dm;
    assign pg_opcode = q.pg_op;
    assign pg_dummy  = q.pg_dm;
    assign inited    = q.inited;

    // Last issued opcode, kept for the ordering check below.
    logic [7:0] prev_op_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       prev_op_q <= '0;
        else if (cmd_req) prev_op_q <= cmd_opcode;
    end

    assert_reg_xfer_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> (cmd_dummy == '0 && cmd_addr_bytes == '0 &&
                     cmd_len == ((cmd_opcode == OP_WREN) ? LEN_W'(0) : LEN_W'(1))));

    assert_wren_before_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && (cmd_opcode == OP_WR_LANE || cmd_opcode == OP_WR_DUMY))
            |-> prev_op_q == OP_WREN);

    assert_lane_after_flash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_lane) |-> $past(cmd_done && cmd_opcode == OP_WR_LANE && cmd_err == '0));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_cmd_only_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> busy);
endmodule

// File: tb/flash_mode_seq_tb.sv
`timescale 1ns/1ps
module flash_mode_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_restore = 1'b0;
    logic [1:0]  req_state = 2'd0;
    logic        busy, done, cmd_req, cmd_wr, inited;
    logic [3:0]  status, cmd_len, cmd_err;
    logic [7:0]  cmd_opcode, rd_opcode, pg_opcode;
    logic [2:0]  cmd_addr_bytes;
    logic [4:0]  cmd_dummy, rd_dummy, pg_dummy;
    logic [63:0] cmd_wdata, cmd_rdata;
    logic        cmd_done;
    logic [1:0]  host_lane;

    always #2.5 clk = ~clk;

    flash_mode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_restore(req_restore),
        .req_state(req_state), .busy(busy), .done(done), .status(status),
        .cmd_req(cmd_req), .cmd_opcode(cmd_opcode), .cmd_wr(cmd_wr),
        .cmd_addr_bytes(cmd_addr_bytes), .cmd_dummy(cmd_dummy), .cmd_len(cmd_len),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .cmd_rdata(cmd_rdata), .host_lane(host_lane), .rd_opcode(rd_opcode),
        .rd_dummy(rd_dummy), .pg_opcode(pg_opcode), .pg_dummy(pg_dummy), .inited(inited)
    );

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Flash model state
    logic [7:0] lane_m, dumy_m;
    logic [7:0] log_op [0:15];
    logic       log_wr [0:15];
    int         log_n = 0;
    int         err_at = -1;
    logic [3:0] err_code = 4'd0;
    logic [1:0] lane_before = 2'd0, lane_after = 2'd0;

    // Expected presented profile
    logic [1:0] e_lane = 0;
    logic [7:0] e_rd = 0, e_pg = 0;
    logic [4:0] e_rdd = 0, e_pgd = 0;
    logic       e_init = 0;

    function automatic logic [7:0] f_lane_edit(input logic [7:0] b, input logic [1:0] lane);
        if (lane == 2'd2) return {2'b01, b[5:0]};
        return {2'b11, b[5:0]};
    endfunction

    function automatic void f_profile(input bit rs, input logic [1:0] st,
        output logic [1:0] ln, output logic [7:0] ro, output logic [4:0] rd,
        output logic [7:0] po, output logic [4:0] pd, output logic [3:0] fd);
        ln = 0; ro = 8'h03; rd = 0; po = 8'h02; pd = 0; fd = 0;
        if (rs) begin fd = 8; end
        else if (st == 1) begin ro = 8'h0B; rd = 8; fd = 8; end
        else if (st == 2) begin ln = 2; ro = 8'h6B; rd = 10; po = 8'h32; fd = 10; end
    endfunction

    // Command responder
    initial begin
        cmd_done = 0; cmd_err = 0; cmd_rdata = 0;
        forever begin
            @(negedge clk);
            while (cmd_req) begin
                automatic logic [7:0] op = cmd_opcode;
                automatic logic [7:0] wb = cmd_wdata[7:0];
                automatic int idx = log_n;
                automatic bit fail_here = (idx == err_at);
                if (idx < 16) begin log_op[idx] = op; log_wr[idx] = cmd_wr; end
                log_n++;
                repeat (1 + $urandom % 3) @(negedge clk);
                cmd_done = 1;
                cmd_err  = fail_here ? err_code : 4'd0;
                cmd_rdata = {$urandom, $urandom};
                if (op == 8'h65) cmd_rdata[7:0] = lane_m;
                if (op == 8'h85) cmd_rdata[7:0] = dumy_m;
                if (!fail_here) begin
                    if (op == 8'h61) lane_m = wb;
                    if (op == 8'h81) dumy_m = wb;
                end
                if (op == 8'h61 && !fail_here)
                    check(host_lane == lane_before, "R6 lane before flash write done", host_lane, lane_before);
                @(negedge clk);
                cmd_done = 0; cmd_err = 0;
                if (op == 8'h61 && !fail_here)
                    check(host_lane == lane_after, "R6 lane after flash write done", host_lane, lane_after);
            end
        end
    end

    task automatic run_req(input bit rs, input logic [1:0] st, input int e,
                           input logic [3:0] code, input bit poke);
        logic [1:0] tl; logic [7:0] ro, po; logic [4:0] rdd, pgd; logic [3:0] fd;
        logic [7:0] l0, d0, exp_l, exp_d;
        logic [7:0] seq [0:5];
        int nexp, t;
        bit bad;
        seq[0] = 8'h65; seq[1] = 8'h06; seq[2] = 8'h61;
        seq[3] = 8'h85; seq[4] = 8'h06; seq[5] = 8'h81;
        f_profile(rs, st, tl, ro, rdd, po, pgd, fd);
        bad = !rs && st == 2'd3;
        l0 = lane_m; d0 = dumy_m;
        lane_before = e_lane; lane_after = tl;
        log_n = 0; err_at = e; err_code = code;
        @(negedge clk);
        req_valid = 1; req_restore = rs; req_state = st;
        @(negedge clk);
        req_valid = 0;
        if (bad) begin
            check(done && status == 4'hF && !busy, "R8 bad profile rejected", {done, status, busy}, 6'b111110);
            @(negedge clk);
            check(!done, "R11 done one cycle", done, 0);
            check(log_n == 0 && lane_m == l0 && dumy_m == d0, "R8 no commands", log_n, 0);
            check(host_lane == e_lane && inited == e_init, "R8 state kept", host_lane, e_lane);
            return;
        end
        check(busy && !done, "R10 busy after accept", busy, 1);
        if (poke) begin
            req_valid = 1; req_restore = 0; req_state = (st == 2) ? 2'd0 : 2'd2;
            @(negedge clk);
            req_valid = 0;
        end
        t = 0;
        while (!done && t < 500) begin
            check(busy, "R10 busy held until done", busy, 1);
            @(negedge clk); t++;
        end
        check(done && !busy, "R10 done ends busy", {done, busy}, 2'b10);
        nexp = (e >= 0) ? e + 1 : 6;
        check(log_n == nexp, "R9 command count", log_n, nexp);
        for (int i = 0; i < nexp && i < log_n; i++) begin
            check(log_op[i] == seq[i], "R2 command order", log_op[i], seq[i]);
            check(log_wr[i] == (i != 0 && i != 3), "R2 command direction", log_wr[i], (i != 0 && i != 3));
        end
        check(status == ((e >= 0) ? code : 4'd0), "R9 R11 status", status, (e >= 0) ? code : 4'd0);
        exp_l = (e < 0 || e > 2) ? f_lane_edit(l0, tl) : l0;
        exp_d = (e < 0) ? {fd, d0[3:0]} : d0;
        check(lane_m == exp_l, "R3 lane byte edit", lane_m, exp_l);
        check(dumy_m == exp_d, "R4 dummy byte edit", dumy_m, exp_d);
        if (e < 0 || e > 2) e_lane = tl;
        if (e < 0) begin
            if (rs) begin e_rd = 0; e_rdd = 0; e_pg = 0; e_pgd = 0; e_init = 0; end
            else begin e_rd = ro; e_rdd = rdd; e_pg = po; e_pgd = pgd; e_init = 1; end
        end
        check(host_lane == e_lane, rs ? "R7 lane" : "R6 lane", host_lane, e_lane);
        check({rd_opcode, rd_dummy, pg_opcode, pg_dummy, inited} == {e_rd, e_rdd, e_pg, e_pgd, e_init},
              rs ? "R7 restore profile" : "R5 profile outputs",
              {rd_opcode, rd_dummy, pg_opcode, pg_dummy, inited}, {e_rd, e_rdd, e_pg, e_pgd, e_init});
        @(negedge clk);
        check(!done, "R11 done one cycle", done, 0);
        check(status == ((e >= 0) ? code : 4'd0), "R11 status held", status, (e >= 0) ? code : 4'd0);
    endtask

    initial begin
        bit wd_hit = 0;
        fork
            begin : wd
                repeat (150000) @(posedge clk);
                wd_hit = 1;
            end
            begin : main_seq
                void'($urandom(32'h5eed));
                lane_m = 8'h3C; dumy_m = 8'hFB;
                repeat (3) @(negedge clk);
                check({busy, done, status, cmd_req, inited, host_lane} == 0, "R1 reset state",
                      {busy, done, status, cmd_req, inited, host_lane}, 0);
                check({rd_opcode, rd_dummy, pg_opcode, pg_dummy} == 0, "R1 reset profile",
                      {rd_opcode, rd_dummy, pg_opcode, pg_dummy}, 0);
                rst_n = 1;
                @(negedge clk);
                check(!cmd_req && !busy, "R1 idle after reset", {cmd_req, busy}, 0);
                run_req(0, 2, -1, 0, 0);
                run_req(0, 1, -1, 0, 1);
                run_req(0, 0, -1, 0, 0);
                run_req(0, 3, -1, 0, 0);
                run_req(0, 2, 4, 4'd5, 0);
                run_req(0, 2, 1, 4'd3, 0);
                run_req(1, 0, -1, 0, 0);
                run_req(0, 2, 5, 4'd9, 0);
                run_req(1, 3, -1, 0, 1);
                for (int k = 0; k < 60; k++) begin
                    automatic bit rs = ($urandom % 5) == 0;
                    automatic logic [1:0] st = 2'($urandom % 4);
                    automatic int e = (($urandom % 4) == 0) ? int'($urandom % 6) : -1;
                    automatic logic [3:0] c = 4'(1 + $urandom % 14);
                    if ($urandom % 3 == 0) begin lane_m = 8'($urandom); dumy_m = 8'($urandom); end
                    run_req(rs, st, e, c, (e < 0) && ($urandom % 2 == 0));
                end
            end
        join_any
        disable fork;
        if (wd_hit) check(0, "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule